// File: doc/BRIEF.md
# Flash Operation Completion Detector

This block decides when a parallel NOR flash device has finished an embedded program or erase operation. After a start pulse it repeatedly reads one status location through a bus master and inspects the returned byte. It can run in one of two modes. In toggle mode the device flips one status bit on every read while it is busy, and the operation is complete once two reads in a row return the same value of that bit. In data-poll mode the device returns the complement of the written bit until it is finished, so the operation is complete once that bit matches the bit of the data that was written.

An optional wait, given in clock cycles, can be placed before every status read. Long waits suit erase operations and a zero wait suits byte programming. The block stops after a fixed maximum number of reads and reports a timeout. It also raises a warning when an operation needed more reads than a lower threshold, whether it completed or not. The read transaction is a request handshake followed by a returned byte. The bus timing of the read itself belongs to the bus master.

Top module: `flash_done_detect`

## Requirements
- R1: After reset and whenever the block is idle, `busy_o`, `rd_valid_o`, `done_o`, `timeout_o` and `slow_o` are all low.
- R2: With `mode_i` = 0 (toggle mode) only bit 6 of each returned byte matters. The first read of an operation only records bit 6 and can never complete it. Each later read completes the operation when its bit 6 equals that of the previous read. All other bits are ignored.
- R3: With `mode_i` = 1 (data-poll mode) only bit 7 matters. Any read, the first one included, completes the operation when its bit 7 equals bit 7 of `expect_i`. All other bits are ignored.
- R4: A read request holds `rd_valid_o` high until `rd_ready_i` is high at a clock edge. Only one read is outstanding at a time. `rd_addr_o` carries the address captured at start and stays stable for the whole operation.
- R5: With a wait setting W (captured from `wait_cfg_i` at start), `rd_valid_o` rises exactly W+1 cycles after the start is accepted and W+1 cycles after each returned byte that does not end the operation. W = 0 issues the next request on the following cycle.
- R6: When ITER_LIMIT reads have returned without completion, the operation ends with `timeout_o`. A completion on read number ITER_LIMIT counts as done, not as a timeout.
- R7: `slow_o` is raised together with `done_o` or `timeout_o` when the operation used more than WARN_LIMIT reads. It stays low for exactly WARN_LIMIT reads.
- R8: `done_o`, `timeout_o` and `slow_o` are one-cycle pulses on the cycle the block returns to idle (`busy_o` low). `done_o` and `timeout_o` are never high together.
- R9: A start pulse while `busy_o` is high is ignored: the mode, address, expected byte and wait setting of the running operation are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an operation when the block is idle |
| mode_i | input | 1 | 0 = toggle mode, 1 = data-poll mode |
| addr_i | input | ADDR_W | Status location to poll |
| expect_i | input | 8 | Byte that was written (data-poll mode) |
| wait_cfg_i | input | WAIT_W | Wait in cycles before each read |
| rd_valid_o | output | 1 | Read request to the bus master |
| rd_ready_i | input | 1 | Bus master accepts the request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_valid_i | input | 1 | Returned byte is valid |
| rd_data_i | input | 8 | Returned status byte |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Read limit reached without completion |
| slow_o | output | 1 | More than WARN_LIMIT reads were needed |

## Verification
The first request of an operation is due W+1 cycles after the start edge. Each later request is due W+1 cycles after the cycle in which a byte is returned. The bench counts negative edges from each of these events and checks the count at the edge where `rd_valid_o` is first seen high. The end flags are due one cycle after the deciding byte is sampled. The bench looks for them on the next negative edge and checks on the edge after that that they have dropped. It compares the number of returned bytes with its own count of the reads each scripted status sequence requires.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_POLL   = 1'b1
  } fcd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_RESP
  } fcd_state_e;

  localparam int TOGGLE_BIT = 6;
  localparam int POLL_BIT   = 7;

  // toggle mode: settled once a reference exists and the bit repeats
  function automatic logic toggle_settled(logic have_ref, logic ref_bit,
                                          logic [7:0] sample);
    return have_ref && (ref_bit == sample[TOGGLE_BIT]);
  endfunction

  // data-poll mode: settled once the polled bit equals the written bit
  function automatic logic poll_settled(logic [7:0] expect_byte,
                                        logic [7:0] sample);
    return sample[POLL_BIT] == expect_byte[POLL_BIT];
  endfunction

  function automatic logic count_reaches(int unsigned n, int unsigned lim);
    return n >= lim;
  endfunction

  function automatic logic count_exceeds(int unsigned n, int unsigned lim);
    return n > lim;
  endfunction

endpackage

// File: rtl/fcd_wait_timer.sv
`timescale 1ns/1ps
module fcd_wait_timer #(
  parameter int WAIT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expire
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == WAIT_W'(1));

endmodule

// File: rtl/fcd_read_counter.sv
`timescale 1ns/1ps
module fcd_read_counter #(
  parameter int CNT_W      = 28,
  parameter int ITER_LIMIT = 32'h0FFF_FFFF,
  parameter int WARN_LIMIT = 32'h0010_0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last_read,
  output logic over_warn
);
  import fcd_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next  = {1'b0, cnt_q} + 1'b1;
  assign last_read = count_reaches(32'(cnt_next), ITER_LIMIT);
  assign over_warn = count_exceeds(32'(cnt_next), WARN_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (bump) begin
      cnt_q <= cnt_next[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/fcd_status_eval.sv
`timescale 1ns/1ps
module fcd_status_eval (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                capture,
  input  fcd_pkg::fcd_mode_e  mode,
  input  logic [7:0]          expect_byte,
  input  logic [7:0]          sample,
  output logic                settle
);
  import fcd_pkg::*;

  logic have_ref_q;
  logic ref_bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      ref_bit_q  <= 1'b0;
    end else if (clear) begin
      have_ref_q <= 1'b0;
    end else if (capture) begin
      have_ref_q <= 1'b1;
      ref_bit_q  <= sample[TOGGLE_BIT];
    end
  end

  always_comb begin
    if (mode == MODE_TOGGLE) settle = toggle_settled(have_ref_q, ref_bit_q, sample);
    else                     settle = poll_settled(expect_byte, sample);
  end

endmodule

// File: rtl/flash_done_detect.sv
`timescale 1ns/1ps
module flash_done_detect #(
  parameter int ADDR_W     = 24,
  parameter int WAIT_W     = 24,
  parameter int ITER_LIMIT = 32'h0FFF_FFFF,
  parameter int WARN_LIMIT = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        expect_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_data_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              slow_o
);
  import fcd_pkg::*;

  localparam int CNT_W = $clog2(ITER_LIMIT + 1);

  fcd_state_e        state_q, state_d;
  fcd_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        exp_q;
  logic [WAIT_W-1:0] wait_q;
  logic              done_q, timeout_q, slow_q;

  // named internal events
  logic start_fire, rd_fire, resp_fire, finish;
  logic settle_hit, limit_hit, warn_hit, wait_expire;
  logic timer_load;
  logic [WAIT_W-1:0] timer_val;

  assign start_fire = (state_q == ST_IDLE) && start_i;
  assign rd_fire    = (state_q == ST_REQ)  && rd_ready_i;
  assign resp_fire  = (state_q == ST_RESP) && rd_data_valid_i;
  assign finish     = resp_fire && (settle_hit || limit_hit);

  assign timer_load = (start_fire && (wait_cfg_i != '0)) ||
                      (resp_fire && !finish && (wait_q != '0));
  assign timer_val  = start_fire ? wait_cfg_i : wait_q;

  fcd_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expire   (wait_expire)
  );

  fcd_read_counter #(
    .CNT_W      (CNT_W),
    .ITER_LIMIT (ITER_LIMIT),
    .WARN_LIMIT (WARN_LIMIT)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_fire),
    .bump      (resp_fire),
    .last_read (limit_hit),
    .over_warn (warn_hit)
  );

  fcd_status_eval u_eval (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_fire),
    .capture     (resp_fire),
    .mode        (mode_q),
    .expect_byte (exp_q),
    .sample      (rd_data_i),
    .settle      (settle_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_fire) state_d = (wait_cfg_i != '0) ? ST_WAIT : ST_REQ;
      ST_WAIT: if (wait_expire) state_d = ST_REQ;
      ST_REQ:  if (rd_fire) state_d = ST_RESP;
      ST_RESP: if (resp_fire) begin
        if (finish)              state_d = ST_IDLE;
        else if (wait_q != '0)   state_d = ST_WAIT;
        else                     state_d = ST_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_TOGGLE;
      addr_q    <= '0;
      exp_q     <= '0;
      wait_q    <= '0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
      slow_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_q    <= finish && settle_hit;
      timeout_q <= finish && !settle_hit;
      slow_q    <= finish && warn_hit;
      if (start_fire) begin
        mode_q <= fcd_mode_e'(mode_i);
        addr_q <= addr_i;
        exp_q  <= expect_i;
        wait_q <= wait_cfg_i;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign rd_valid_o = (state_q == ST_REQ);
  assign rd_addr_o  = addr_q;
  assign done_o     = done_q;
  assign timeout_o  = timeout_q;
  assign slow_o     = slow_q;

endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              timeout,
  input logic              slow,
  input logic              resp_fire,
  input logic              settle_hit,
  input logic              limit_hit
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid) else $error("idle request");                      // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid) else $error("request dropped");  // R4

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr)) else $error("addr moved"); // R4

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(resp_fire && settle_hit)) else $error("done cause");    // R2

  AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(resp_fire && limit_hit && !settle_hit))
    else $error("timeout cause");                                          // R6

  AST_SLOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    slow |-> (done || timeout)) else $error("stray warning");              // R7

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)) else $error("done and timeout");                   // R8

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy) else $error("end while busy");            // R8

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !(done || timeout)) else $error("long pulse");   // R8

endmodule

bind flash_done_detect fcd_checker #(.ADDR_W(ADDR_W)) u_fcd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_o),
  .rd_valid   (rd_valid_o),
  .rd_ready   (rd_ready_i),
  .rd_addr    (rd_addr_o),
  .done       (done_o),
  .timeout    (timeout_o),
  .slow       (slow_o),
  .resp_fire  (resp_fire),
  .settle_hit (settle_hit),
  .limit_hit  (limit_hit)
);

// File: tb/flash_done_detect_bench.sv
`timescale 1ns/1ps
module flash_done_detect_bench;

  localparam int ADDR_W = 24;
  localparam int WAIT_W = 8;
  localparam int LIMIT  = 20;
  localparam int WARN   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        expect_i = '0;
  logic [WAIT_W-1:0] wait_cfg_i = '0;
  logic              rd_valid_o;
  logic              rd_ready_i = 1'b1;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rd_data_valid_i = 1'b0;
  logic [7:0]        rd_data_i = '0;
  logic              busy_o, done_o, timeout_o, slow_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_done_detect #(
    .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .ITER_LIMIT(LIMIT), .WARN_LIMIT(WARN)
  ) u_flash_done_detect (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .expect_i(expect_i), .wait_cfg_i(wait_cfg_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_data_valid_i(rd_data_valid_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .slow_o(slow_o)
  );

  // fields: mode(1) expect(8) wait(8) settle-index K(8) stall(1)
  localparam int NVEC = 11;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 8'd0, 8'd0,  1'b0},
    {1'b0, 8'h00, 8'd3, 8'd5,  1'b1},
    {1'b1, 8'h80, 8'd0, 8'd0,  1'b0},
    {1'b1, 8'h3F, 8'd2, 8'd4,  1'b1},
    {1'b0, 8'h00, 8'd0, 8'd7,  1'b0},
    {1'b1, 8'hFF, 8'd1, 8'd7,  1'b0},
    {1'b1, 8'h80, 8'd0, 8'd8,  1'b0},
    {1'b0, 8'h00, 8'd0, 8'd30, 1'b0},
    {1'b1, 8'h00, 8'd0, 8'd19, 1'b0},
    {1'b1, 8'h80, 8'd0, 8'd20, 1'b0},
    {1'b0, 8'h00, 8'd5, 8'd1,  1'b1}
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scripted status byte for read number i (0-based)
  function automatic logic [7:0] stat_byte(logic m, logic [7:0] e, int k, int i);
    logic [7:0] b;
    b[5:0] = 6'(i * 37);
    if (!m) begin
      b[6] = 1'((((i < k) ? i : k)) & 1);
      b[7] = 1'(i & 1);
    end else begin
      b[7] = (i >= k) ? e[7] : ~e[7];
      b[6] = 1'(i & 1);
    end
    return b;
  endfunction

  // reads needed to settle: toggle K+2, data-poll K+1
  function automatic int reads_needed(logic m, int k);
    return m ? k + 1 : k + 2;
  endfunction

  task automatic run_op(string tag, logic m, logic [7:0] e, int w, int k,
                        logic stall, logic [ADDR_W-1:0] a, logic inject);
    int reads = 0, gap = 0, gap_err = 0, addr_err = 0, cyc = 0;
    int need, exp_reads;
    logic pend = 1'b0, awaiting = 1'b1, fin = 1'b0;
    logic got_done = 1'b0, got_to = 1'b0, got_slow = 1'b0;
    @(negedge clk);
    mode_i = m; expect_i = e; wait_cfg_i = WAIT_W'(w); addr_i = a;
    start_i = 1'b1; rd_ready_i = 1'b1;
    while (!fin && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (inject && cyc == 3) begin   // R9: start while busy
        start_i = 1'b1; mode_i = ~m; addr_i = ~a; wait_cfg_i = '0; expect_i = ~e;
      end
      rd_data_valid_i = 1'b0;
      if (done_o || timeout_o) begin
        fin = 1'b1; got_done = done_o; got_to = timeout_o; got_slow = slow_o;
        chk("R8", {tag, " idle at end"}, int'(busy_o), 0);
      end
      if (pend) begin
        rd_data_valid_i = 1'b1;
        rd_data_i = stat_byte(m, e, k, reads);
        reads++; gap = 0; awaiting = 1'b1; pend = 1'b0;
      end else begin
        gap++;
        if (awaiting && rd_valid_o) begin
          awaiting = 1'b0;
          if (gap != w + 1) gap_err++;
        end
      end
      rd_ready_i = stall ? ~rd_ready_i : 1'b1;
      if (rd_valid_o && rd_ready_i) begin
        pend = 1'b1;
        if (rd_addr_o != a) addr_err++;
      end
    end
    need      = reads_needed(m, k);
    exp_reads = (need <= LIMIT) ? need : LIMIT;
    chk("R2/R3 R6", {tag, " reads"}, reads, exp_reads);
    chk("R2/R3", {tag, " done"}, int'(got_done), int'(need <= LIMIT));
    chk("R6", {tag, " timeout"}, int'(got_to), int'(need > LIMIT));
    chk("R7", {tag, " slow"}, int'(got_slow), int'(exp_reads > WARN));
    chk("R5", {tag, " wait gaps"}, gap_err, 0);
    chk("R4", {tag, " address"}, addr_err, 0);
    @(negedge clk);
    chk("R8", {tag, " pulse drop"}, int'(done_o | timeout_o | slow_o), 0);
    chk("R1", {tag, " idle request"}, int'(rd_valid_o | busy_o), 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset busy", int'(busy_o), 0);
    chk("R1", "reset flags", int'(done_o | timeout_o | slow_o), 0);
    chk("R1", "reset request", int'(rd_valid_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", int'(busy_o | rd_valid_o), 0);

    for (int v = 0; v < NVEC; v++) begin
      run_op($sformatf("vec%0d", v), VEC[v][25], VEC[v][24:17],
             int'(VEC[v][16:9]), int'(VEC[v][8:1]), VEC[v][0],
             ADDR_W'(24'h5A0000 + v), 1'b0);
    end

    // R9: a start during an operation leaves it untouched
    run_op("R9 ignored start", 1'b0, 8'h00, 2, 3, 1'b0, 24'h00ABCD, 1'b1);
    // R2: toggling bit 7 alone never ends a toggle-mode run before bit 6 repeats
    run_op("R2 long toggle", 1'b0, 8'h00, 0, 12, 1'b1, 24'h001234, 1'b0);
    // R3: expected byte with bit 7 low, other bits ignored
    run_op("R3 low bit", 1'b1, 8'h7F, 4, 2, 1'b0, 24'h000777, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule